// File: doc/BRIEF.md
# Three-Class Rotating Bus Arbiter

This block decides which agent owns the system bus. The agents fall into three classes. The first is a periodic memory refresh requester. The second is a shared class made up of the host CPU and a configurable number of expansion bus masters. The third is the DMA engine. Service rotates among the three classes. Inside the shared class, the CPU and the masters take turns in a fixed cyclic order. Each agent raises its own request line and receives its own grant line. When no agent asks for the bus, the CPU keeps it.

An owner is displaced by withdrawing its grant while it still requests and another agent is waiting. Once the grant is withdrawn, the owner must let go of its request within a parameterised number of clocks. If it does not, the arbiter takes the bus back by force and raises a one-clock error pulse. A lock input, asserted by the current owner, keeps the arbiter from starting such a withdrawal. A refresh owner is never displaced and keeps the bus until its request falls. Every decision is made at a clock edge from registered state, so grants and the owner code change only on edges.

Top module: `tri_rotor_arbiter`

## Requirements
- R1: While reset is held, and on the first clock after it, the CPU grant is the only grant asserted, the owner code is 1 and the error pulse is low.
- R2: Owner codes are: 0 for refresh, 1 for the CPU, 2+i for master i, and NUM_MASTERS+2 for DMA. The grant outputs are the one-hot decode of the owner code, except while a withdrawal is pending, when all grants are low and the owner code still names the old owner.
- R3: At each handover the classes are searched in the cyclic order refresh, shared, DMA, starting with the class after the one served last. Classes with no request are skipped.
- R4: Inside the shared class, the search starts after the agent served last and follows the cyclic order CPU, master 0 … master N-1, CPU. Agents that do not request are skipped.
- R5: Suppose an owner other than refresh holds its grant and keeps requesting, another agent requests, and lock is low. Then all grants fall at the next edge and the owner code is unchanged.
- R6: When the owner's request is low at an edge and some other agent requests, the bus passes at that edge to the agent chosen by R3 and R4. No grant rises for an agent other than the CPU unless that agent was requesting.
- R7: If a withdrawn owner still requests at the RELEASE_LIMIT-th edge after withdrawal, the bus passes at that edge to the next winner, with the old owner excluded, and the error pulse is high for exactly one clock. If the owner drops its request at that last edge, the handover happens with no error pulse.
- R8: While lock is high, a granted owner that keeps requesting keeps both its grant and its owner code.
- R9: A refresh owner keeps its grant for as long as its request stays high, whatever else requests.
- R10: When no agent requests and the owner has released, the bus returns to the CPU (code 1) at the next edge and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refreshReq | input | 1 | Refresh requester asks for the bus |
| cpuReq | input | 1 | CPU asks for the bus |
| masterReq | input | NUM_MASTERS | Per-master bus request |
| dmaReq | input | 1 | DMA engine asks for the bus |
| lockIn | input | 1 | Current owner forbids withdrawal of its grant |
| refreshGnt | output | 1 | Refresh requester owns the bus |
| cpuGnt | output | 1 | CPU owns the bus |
| masterAck | output | NUM_MASTERS | Per-master acknowledge (grant) |
| dmaGnt | output | 1 | DMA engine owns the bus |
| timeoutErr | output | 1 | One-clock pulse when a withdrawn owner failed to release |
| ownerId | output | OWNER_W | Code of the current owner (see R2) |

## Verification
Two functions can fall on the same edge. The first is the forced takeover when the release window runs out. The second is the voluntary release at the window's final edge. The bench holds a withdrawn master's request for exactly one edge short of the limit and then drops it. It checks that the bus passes to the waiting DMA agent with no error pulse. It also makes a second master overstay by one edge and checks that the pulse then appears for a single clock. Lock and a pending preemption also coincide. With lock high and a rival waiting, the owner must keep its grant edge after edge, and the withdrawal must appear on the first edge after lock falls.

// File: rtl/tri_rotor_pkg.sv
package tri_rotor_pkg;

  // Top-level service classes; the numeric order is the rotation order.
  typedef enum logic [1:0] {
    CLS_REFRESH = 2'd0,
    CLS_SHARED  = 2'd1,
    CLS_DMA     = 2'd2
  } busClass_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic handover;     // load a new owner this edge
    logic startRevoke;  // withdraw the owner's grant this edge
    logic timeout;      // handover is forced by an expired window
  } arbStrobe_t;

endpackage

// File: rtl/tri_rotor_pick.sv
// Two-level rotating search: class rotation on top, agent rotation inside
// the shared (CPU + masters) class.
module tri_rotor_pick
  import tri_rotor_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int AGENTS  = NUM_MASTERS + 3,
  localparam int SH_N    = NUM_MASTERS + 1,
  localparam int OWNER_W = $clog2(AGENTS),
  localparam int SH_W    = (SH_N > 1) ? $clog2(SH_N) : 1
) (
  input  logic [AGENTS-1:0]  candVec,
  input  busClass_e          lastClass,
  input  logic [SH_W-1:0]    sharedPtr,
  output logic               winValid,
  output logic [OWNER_W-1:0] winner
);

  logic [SH_N-1:0] shReq;
  logic [2:0]      classReq;
  logic            shFound;
  logic [SH_W-1:0] shIdx;
  logic            clsFound;
  busClass_e       clsPick;

  assign shReq    = candVec[AGENTS-2:1];
  assign classReq = {candVec[AGENTS-1], |shReq, candVec[0]};

  // Shared-class search, starting just after the last served agent.
  always_comb begin
    int s;
    shFound = 1'b0;
    shIdx   = '0;
    for (int k = 1; k <= SH_N; k++) begin
      s = int'(sharedPtr) + k;
      if (s >= SH_N) s = s - SH_N;
      if (!shFound && shReq[s]) begin
        shFound = 1'b1;
        shIdx   = SH_W'(s);
      end
    end
  end

  // Class search, starting just after the last served class.
  always_comb begin
    int c;
    clsFound = 1'b0;
    clsPick  = CLS_SHARED;
    for (int k = 1; k <= 3; k++) begin
      c = int'(lastClass) + k;
      if (c >= 3) c = c - 3;
      if (!clsFound && classReq[c]) begin
        clsFound = 1'b1;
        clsPick  = busClass_e'(c[1:0]);
      end
    end
  end

  always_comb begin
    winValid = clsFound;
    unique case (clsPick)
      CLS_REFRESH: winner = '0;
      CLS_DMA:     winner = OWNER_W'(AGENTS - 1);
      default:     winner = OWNER_W'(shIdx) + OWNER_W'(1);
    endcase
  end

endmodule

// File: rtl/tri_rotor_ctrl.sv
// Decides handover / withdrawal each edge and times the release window.
module tri_rotor_ctrl
  import tri_rotor_pkg::*;
#(
  parameter int NUM_MASTERS   = 4,
  parameter int RELEASE_LIMIT = 64,
  localparam int AGENTS  = NUM_MASTERS + 3,
  localparam int OWNER_W = $clog2(AGENTS),
  localparam int CNT_W   = $clog2(RELEASE_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [AGENTS-1:0]  reqVec,
  input  logic [OWNER_W-1:0] owner,
  input  logic               revoking,
  input  logic               lockIn,
  input  logic               winValid,
  output arbStrobe_t         strobe
);

  localparam logic [OWNER_W-1:0] CPU_CODE = OWNER_W'(1);
  localparam logic [OWNER_W-1:0] REF_CODE = OWNER_W'(0);

  logic [CNT_W-1:0] waitCnt;
  logic             ownerReq;
  logic             windowEnd;

  assign ownerReq  = reqVec[owner];
  assign windowEnd = (waitCnt == CNT_W'(RELEASE_LIMIT - 1));

  always_comb begin
    strobe = '0;
    if (!revoking) begin
      if (!ownerReq) begin
        if (winValid || owner != CPU_CODE) strobe.handover = 1'b1;
      end else if (owner != REF_CODE && winValid && !lockIn) begin
        strobe.startRevoke = 1'b1;
      end
    end else begin
      if (!ownerReq) begin
        strobe.handover = 1'b1;
      end else if (windowEnd) begin
        strobe.handover = 1'b1;
        strobe.timeout  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.startRevoke) begin
      waitCnt <= '0;
    end else if (revoking && ownerReq && !strobe.timeout) begin
      waitCnt <= waitCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tri_rotor_dp.sv
// Owner / rotation-pointer registers and grant decode.
module tri_rotor_dp
  import tri_rotor_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int AGENTS  = NUM_MASTERS + 3,
  localparam int SH_N    = NUM_MASTERS + 1,
  localparam int OWNER_W = $clog2(AGENTS),
  localparam int SH_W    = (SH_N > 1) ? $clog2(SH_N) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobe_t         strobe,
  input  logic               winValid,
  input  logic [OWNER_W-1:0] winner,
  output logic [OWNER_W-1:0] owner,
  output logic               revoking,
  output busClass_e          lastClass,
  output logic [SH_W-1:0]    sharedPtr,
  output logic [AGENTS-1:0]  grantVec,
  output logic               timeoutErr
);

  localparam logic [OWNER_W-1:0] CPU_CODE = OWNER_W'(1);
  localparam logic [OWNER_W-1:0] DMA_CODE = OWNER_W'(AGENTS - 1);

  logic [OWNER_W-1:0] target;
  busClass_e          targetClass;

  assign target = winValid ? winner : CPU_CODE;

  always_comb begin
    if (target == '0)           targetClass = CLS_REFRESH;
    else if (target == DMA_CODE) targetClass = CLS_DMA;
    else                         targetClass = CLS_SHARED;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner      <= CPU_CODE;
      revoking   <= 1'b0;
      lastClass  <= CLS_SHARED;
      sharedPtr  <= '0;
      timeoutErr <= 1'b0;
    end else begin
      timeoutErr <= strobe.timeout;
      if (strobe.handover) begin
        owner     <= target;
        revoking  <= 1'b0;
        lastClass <= targetClass;
        if (targetClass == CLS_SHARED) sharedPtr <= SH_W'(target - OWNER_W'(1));
      end else if (strobe.startRevoke) begin
        revoking <= 1'b1;
      end
    end
  end

  always_comb begin
    grantVec = '0;
    if (!revoking) grantVec[owner] = 1'b1;
  end

endmodule

// File: rtl/tri_rotor_arbiter.sv
module tri_rotor_arbiter
  import tri_rotor_pkg::*;
#(
  parameter int NUM_MASTERS   = 4,
  parameter int RELEASE_LIMIT = 64,
  localparam int AGENTS  = NUM_MASTERS + 3,
  localparam int SH_N    = NUM_MASTERS + 1,
  localparam int OWNER_W = $clog2(AGENTS),
  localparam int SH_W    = (SH_N > 1) ? $clog2(SH_N) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   refreshReq,
  input  logic                   cpuReq,
  input  logic [NUM_MASTERS-1:0] masterReq,
  input  logic                   dmaReq,
  input  logic                   lockIn,
  output logic                   refreshGnt,
  output logic                   cpuGnt,
  output logic [NUM_MASTERS-1:0] masterAck,
  output logic                   dmaGnt,
  output logic                   timeoutErr,
  output logic [OWNER_W-1:0]     ownerId
);

  logic [AGENTS-1:0]  reqVec;
  logic [AGENTS-1:0]  candVec;
  logic [AGENTS-1:0]  ownerBit;
  logic [AGENTS-1:0]  grantVec;
  logic [OWNER_W-1:0] owner;
  logic               revoking;
  busClass_e          lastClass;
  logic [SH_W-1:0]    sharedPtr;
  logic               winValid;
  logic [OWNER_W-1:0] winner;
  arbStrobe_t         strobe;

  assign reqVec = {dmaReq, masterReq, cpuReq, refreshReq};

  always_comb begin
    ownerBit        = '0;
    ownerBit[owner] = 1'b1;
  end
  assign candVec = reqVec & ~ownerBit;

  tri_rotor_pick #(.NUM_MASTERS(NUM_MASTERS)) pickInst (
    .candVec  (candVec),
    .lastClass(lastClass),
    .sharedPtr(sharedPtr),
    .winValid (winValid),
    .winner   (winner)
  );

  tri_rotor_ctrl #(.NUM_MASTERS(NUM_MASTERS), .RELEASE_LIMIT(RELEASE_LIMIT)) ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .reqVec  (reqVec),
    .owner   (owner),
    .revoking(revoking),
    .lockIn  (lockIn),
    .winValid(winValid),
    .strobe  (strobe)
  );

  tri_rotor_dp #(.NUM_MASTERS(NUM_MASTERS)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .winValid  (winValid),
    .winner    (winner),
    .owner     (owner),
    .revoking  (revoking),
    .lastClass (lastClass),
    .sharedPtr (sharedPtr),
    .grantVec  (grantVec),
    .timeoutErr(timeoutErr)
  );

  assign refreshGnt = grantVec[0];
  assign cpuGnt     = grantVec[1];
  assign masterAck  = grantVec[AGENTS-2:2];
  assign dmaGnt     = grantVec[AGENTS-1];
  assign ownerId    = owner;

endmodule

// File: rtl/tri_rotor_chk.sv
module tri_rotor_chk #(
  parameter int NUM_MASTERS   = 4,
  parameter int RELEASE_LIMIT = 64,
  localparam int AGENTS  = NUM_MASTERS + 3,
  localparam int OWNER_W = $clog2(AGENTS),
  localparam int RUN_W   = $clog2(RELEASE_LIMIT + 2) + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [AGENTS-1:0]  reqVec,
  input logic [AGENTS-1:0]  grantVec,
  input logic               lockIn,
  input logic               timeoutErr,
  input logic [OWNER_W-1:0] ownerId
);

  logic             ownerReq;
  logic [RUN_W-1:0] zeroRun;

  assign ownerReq = reqVec[ownerId];

  always_ff @(posedge clk) begin
    if (!rstN)          zeroRun <= '0;
    else if (|grantVec) zeroRun <= '0;
    else                zeroRun <= zeroRun + RUN_W'(1);
  end

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  assert_timeout_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr);

  assert_revoke_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    zeroRun <= RUN_W'(RELEASE_LIMIT));

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|grantVec && lockIn && ownerReq) |=> (ownerId == $past(ownerId) && |grantVec));

  assert_refresh_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec[0] && reqVec[0]) |=> grantVec[0]);

  for (genvar k = 0; k < AGENTS; k++) begin : gReqBeforeGrant
    if (k != 1) begin : gNonCpu
      assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (!rstN)
        $rose(grantVec[k]) |-> $past(reqVec[k]));
    end
  end

endmodule

bind tri_rotor_arbiter tri_rotor_chk #(
  .NUM_MASTERS  (NUM_MASTERS),
  .RELEASE_LIMIT(RELEASE_LIMIT)
) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .reqVec    ({dmaReq, masterReq, cpuReq, refreshReq}),
  .grantVec  ({dmaGnt, masterAck, cpuGnt, refreshGnt}),
  .lockIn    (lockIn),
  .timeoutErr(timeoutErr),
  .ownerId   (ownerId)
);

// File: tb/tri_rotor_arbiter_test.sv
`timescale 1ns/1ps
module tri_rotor_arbiter_test;

  localparam int NM    = 2;
  localparam int LIMIT = 8;
  localparam int NA    = NM + 3;
  localparam int OW    = $clog2(NA);
  localparam int DMA   = NA - 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic          refreshReq, cpuReq, dmaReq, lockIn;
  logic [NM-1:0] masterReq;
  logic          refreshGnt, cpuGnt, dmaGnt, timeoutErr;
  logic [NM-1:0] masterAck;
  logic [OW-1:0] ownerId;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tri_rotor_arbiter #(.NUM_MASTERS(NM), .RELEASE_LIMIT(LIMIT)) uut (
    .clk(clk), .rstN(rstN),
    .refreshReq(refreshReq), .cpuReq(cpuReq), .masterReq(masterReq),
    .dmaReq(dmaReq), .lockIn(lockIn),
    .refreshGnt(refreshGnt), .cpuGnt(cpuGnt), .masterAck(masterAck),
    .dmaGnt(dmaGnt), .timeoutErr(timeoutErr), .ownerId(ownerId)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic setReq(input logic [NA-1:0] v);
    {dmaReq, masterReq, cpuReq, refreshReq} = v;
  endtask

  // Expected grant vector follows R2: one-hot of owner, zero while withdrawn.
  task automatic check(input string tag, input int expOwner, input bit revoked, input bit expTo);
    logic [NA-1:0] gotG;
    logic [NA-1:0] expG;
    gotG = {dmaGnt, masterAck, cpuGnt, refreshGnt};
    expG = revoked ? '0 : NA'(1 << expOwner);
    checks++;
    if (int'(ownerId) != expOwner || gotG != expG || timeoutErr != expTo) begin
      errors++;
      $display("FAIL %s: owner=%0d grants=%b err=%b expected owner=%0d grants=%b err=%b",
               tag, ownerId, gotG, timeoutErr, expOwner, expG, expTo);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; lockIn = 1'b0; setReq('0);
    repeat (3) cyc();
    check("R1 reset", 1, 0, 0);
    rstN = 1'b1;
    cyc();
    check("R1 after reset", 1, 0, 0);

    // R3 rotation: refresh and DMA together, last served = shared -> DMA first.
    refreshReq = 1; dmaReq = 1;
    cyc(); check("R3 shared->dma", DMA, 0, 0);
    cyc(); check("R5 dma withdrawn", DMA, 1, 0);
    dmaReq = 0;
    cyc(); check("R6 release to refresh", 0, 0, 0);
    dmaReq = 1; masterReq = 2'b01;
    for (int i = 0; i < 3; i++) begin
      cyc(); check("R9 refresh kept", 0, 0, 0);
    end
    refreshReq = 0;
    cyc(); check("R3 refresh->shared before dma", 2, 0, 0);
    cyc(); check("R5 master0 withdrawn", 2, 1, 0);
    masterReq = '0;
    cyc(); check("R3 shared->dma", DMA, 0, 0);

    // R4 shared rotation with wrap.
    dmaReq = 0; cpuReq = 1; masterReq = 2'b11;
    cyc(); check("R4 after master0 comes master1", 3, 0, 0);
    cyc(); check("R5 master1 withdrawn", 3, 1, 0);
    masterReq = 2'b01;
    cyc(); check("R4 wrap to cpu", 1, 0, 0);
    cyc(); check("R5 cpu withdrawn", 1, 1, 0);
    cpuReq = 0; lockIn = 1;
    cyc(); check("R4 cpu->master0", 2, 0, 0);

    // R8 lock holds against a waiting master.
    masterReq = 2'b11;
    for (int i = 0; i < 4; i++) begin
      cyc(); check("R8 locked owner kept", 2, 0, 0);
    end
    lockIn = 0;
    cyc(); check("R5 withdrawal after unlock", 2, 1, 0);

    // R7 timeout: master0 overstays.
    for (int i = 1; i < LIMIT; i++) begin
      cyc(); check("R7 inside window", 2, 1, 0);
    end
    cyc(); check("R7 forced handover with pulse", 3, 0, 1);
    masterReq = 2'b10; dmaReq = 1;
    cyc(); check("R7 pulse single, master1 withdrawn", 3, 1, 0);
    for (int i = 1; i < LIMIT; i++) begin
      cyc(); check("R7 inside window 2", 3, 1, 0);
    end
    masterReq = '0;
    cyc(); check("R7 release at last edge, no pulse", DMA, 0, 0);

    // R10 park.
    dmaReq = 0;
    cyc(); check("R10 park to cpu", 1, 0, 0);
    cyc(); check("R10 stays parked", 1, 0, 0);

    // R6 idle cpu hands over at once; R4 skip of idle master0.
    masterReq = 2'b10;
    cyc(); check("R6 immediate handover from idle cpu", 3, 0, 0);

    // Sweep: each lone requester wins from park, then returns to park.
    for (int a = 0; a < NA; a++) begin
      if (a != 1) begin
        setReq('0);
        cyc(); check("R10 sweep park", 1, 0, 0);
        setReq(NA'(1 << a));
        cyc(); check("R6 sweep lone requester", a, 0, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule